// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides when a small 8-bit processor core and its surroundings may run. The CPU writes a two-bit power-control register. One bit requests a light sleep (idle). The other requests a deep sleep (power-down). The block turns those bits into three enables: a CPU clock enable, a peripheral clock enable and an oscillator enable. It also produces an internal reset and a wake vector for the interrupt logic. The oscillator is modelled as an enable plus a programmable settling count; the system clock itself keeps toggling.

The controller is one state machine with four states. RUN has everything enabled. IDLE stops the CPU clock only. PDN (power-down) stops the oscillator and both clocks. SETTLE runs the oscillator but keeps both clocks gated while it stabilises.

The transitions are:
- RUN to IDLE on a write with only the idle bit set.
- RUN to PDN on a write with the power-down bit set.
- IDLE to RUN on an enabled pending interrupt.
- PDN to SETTLE when any active-low external interrupt line is low.
- SETTLE to RUN when the settling count expires.
- Any state to RUN on a qualified internal reset.

The external reset pin is synchronised and must stay high for a minimum number of clocks before it is accepted.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset the mode is RUN (code 00), the control register reads 00, all three enables are 1, the internal reset is 0 and the wake vector is 0.
- R2: In RUN, a write with data 01 enters IDLE (code 01) on the next cycle. The register then reads 01, the CPU clock enable is 0, and the peripheral and oscillator enables stay 1.
- R3: In IDLE, an enabled pending interrupt returns the block to RUN on the next cycle, with register bit 0 cleared by hardware.
- R4: In RUN, a write with data 10 enters PDN (code 10) on the next cycle. The register reads 10, all three enables are 0, and no internal reset is produced.
- R5: A write with data 11 enters PDN, and the register reads 10 (power-down wins over idle).
- R6: In PDN, the general interrupt-pending input has no effect: the mode stays PDN.
- R7: In PDN, a low level on any of the four external interrupt lines enters SETTLE (code 11): the oscillator enable is 1 and both clock enables are 0. SETTLE lasts settle_len_i+1 cycles, then the block returns to RUN with register bit 1 cleared.
- R8: In the first RUN cycle after SETTLE, the wake vector shows, for one cycle, the lines that were low at wake-up (bit i means line i).
- R9: A reset-pin pulse of MACH_CLKS*MIN_MACH clocks (default 8) raises the internal reset for one cycle, SYNC_STAGES+8 cycles after the pin rises. The next cycle shows RUN with the register at 00.
- R10: A reset-pin pulse one clock shorter than that minimum is ignored: the mode and the register are unchanged and the internal reset stays 0.
- R11: A qualified reset pulse also ends PDN and returns the block to RUN.
- R12: Register writes while not in RUN have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| pcon_we_i | input | 1 | Control register write strobe |
| pcon_wdata_i | input | 2 | Write data: bit 0 requests idle, bit 1 requests power-down |
| irq_pend_i | input | 1 | Some enabled interrupt is pending |
| ext_int_n_i | input | 4 | External interrupt lines, active low |
| settle_len_i | input | 8 | Oscillator settling count |
| pcon_o | output | 2 | Control register contents |
| mode_o | output | 2 | Mode: 00 RUN, 01 IDLE, 10 PDN, 11 SETTLE |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| sys_rst_o | output | 1 | Qualified internal reset |
| ext_wake_o | output | 4 | One-cycle wake vector for the interrupt logic |

## Verification
The hardest situation to reach is the edge of the reset filter. A pulse exactly at the minimum width must be told apart from one a single clock shorter, and the result only becomes visible after the synchroniser delay plus the counting window. The stimulus parks the block in IDLE and drives pulses whose width is counted in whole clocks, changing the pin just after an edge. It then follows every cycle up to the one where the reset should or should not appear. The same accepted pulse is repeated from PDN, and a deep-sleep wake is run with both a long and a zero settling count.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    typedef enum logic [1:0] {
        PM_RUN    = 2'b00,
        PM_IDLE   = 2'b01,
        PM_PDN    = 2'b10,
        PM_SETTLE = 2'b11
    } pm_state_t;

    localparam int PCON_IDL = 0;
    localparam int PCON_PDN = 1;
endpackage

// File: rtl/pwr_rst_filter.sv
module pwr_rst_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int MACH_CLKS   = 4,
    parameter int MIN_MACH    = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_i,
    output logic rst_o
);
    localparam int MIN_HI = MACH_CLKS * MIN_MACH;
    localparam int CW     = $clog2(MIN_HI + 1);

    logic [SYNC_STAGES-1:0] sync_r;
    logic                   sync_q;
    logic [CW-1:0]          hi_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_r <= '0;
        else        sync_r <= {sync_r[SYNC_STAGES-2:0], pin_i};
    end

    assign sync_q = sync_r[SYNC_STAGES-1];

    // consecutive high samples, saturating at the minimum width
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                      hi_cnt <= '0;
        else if (!sync_q)                hi_cnt <= '0;
        else if (hi_cnt != CW'(MIN_HI))  hi_cnt <= hi_cnt + 1'b1;
    end

    assign rst_o = (hi_cnt == CW'(MIN_HI));

    // R9
    rst_from_high_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_o) |-> $past(sync_q));
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             active_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                         cnt_q <= '0;
        else if (load_i)                    cnt_q <= load_val_i;
        else if (active_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);

    // R7
    settle_countdown_chk: assert property (@(posedge clk) disable iff (!por_n)
        (active_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
#(
    parameter int N_EXT = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_i,
    input  logic             pcon_we_i,
    input  logic [1:0]       pcon_wdata_i,
    input  logic             irq_pend_i,
    input  logic [N_EXT-1:0] ext_int_n_i,
    input  logic             settle_done_i,
    output logic             settle_load_o,
    output logic             settle_active_o,
    output pm_state_t        state_o,
    output logic [1:0]       pcon_o,
    output logic             cpu_clk_en_o,
    output logic             per_clk_en_o,
    output logic             osc_en_o,
    output logic [N_EXT-1:0] ext_wake_o
);
    pm_state_t        state_q, state_n;
    logic [1:0]       pcon_q, pcon_n;
    logic [N_EXT-1:0] cap_q, cap_n;
    logic             wake_any;
    logic             settle_exit;

    assign wake_any    = |(~ext_int_n_i);
    assign settle_exit = (state_q == PM_SETTLE) && settle_done_i && !sys_rst_i;

    always_comb begin
        state_n = state_q;
        pcon_n  = pcon_q;
        cap_n   = cap_q;
        if (sys_rst_i) begin
            state_n = PM_RUN;
            pcon_n  = '0;
            cap_n   = '0;
        end else begin
            unique case (state_q)
                PM_RUN: begin
                    if (pcon_we_i) begin
                        if (pcon_wdata_i[PCON_PDN]) begin
                            state_n = PM_PDN;
                            pcon_n  = 2'b10;
                        end else if (pcon_wdata_i[PCON_IDL]) begin
                            state_n = PM_IDLE;
                            pcon_n  = 2'b01;
                        end
                    end
                end
                PM_IDLE: begin
                    if (irq_pend_i) begin
                        state_n          = PM_RUN;
                        pcon_n[PCON_IDL] = 1'b0;
                    end
                end
                PM_PDN: begin
                    if (wake_any) begin
                        state_n = PM_SETTLE;
                        cap_n   = ~ext_int_n_i;
                    end
                end
                PM_SETTLE: begin
                    if (settle_done_i) begin
                        state_n          = PM_RUN;
                        pcon_n[PCON_PDN] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q    <= PM_RUN;
            pcon_q     <= '0;
            cap_q      <= '0;
            ext_wake_o <= '0;
        end else begin
            state_q    <= state_n;
            pcon_q     <= pcon_n;
            cap_q      <= cap_n;
            ext_wake_o <= settle_exit ? cap_q : '0;
        end
    end

    always_comb begin
        cpu_clk_en_o = 1'b0;
        per_clk_en_o = 1'b0;
        osc_en_o     = 1'b0;
        unique case (state_q)
            PM_RUN:    begin cpu_clk_en_o = 1'b1; per_clk_en_o = 1'b1; osc_en_o = 1'b1; end
            PM_IDLE:   begin per_clk_en_o = 1'b1; osc_en_o = 1'b1; end
            PM_PDN:    ;
            PM_SETTLE: osc_en_o = 1'b1;
            default:   ;
        endcase
    end

    assign settle_load_o   = (state_q == PM_PDN) && wake_any && !sys_rst_i;
    assign settle_active_o = (state_q == PM_SETTLE);
    assign state_o         = state_q;
    assign pcon_o          = pcon_q;

    // R2
    idle_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == PM_RUN && pcon_we_i && pcon_wdata_i == 2'b01 && !sys_rst_i)
            |=> (state_q == PM_IDLE));
    // R3
    idle_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == PM_IDLE && irq_pend_i && !sys_rst_i)
            |=> (state_q == PM_RUN && !pcon_q[PCON_IDL]));
    // R5
    pdn_priority_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == PM_RUN && pcon_we_i && pcon_wdata_i == 2'b11 && !sys_rst_i)
            |=> (state_q == PM_PDN && pcon_q == 2'b10));
    // R6
    pdn_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == PM_PDN && (&ext_int_n_i) && !sys_rst_i) |=> (state_q == PM_PDN));
    // R8
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ext_wake_o != '0) |-> (state_q == PM_RUN && $past(state_q) == PM_SETTLE));
    // R9
    reset_to_run_chk: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_i |=> (state_q == PM_RUN && pcon_q == 2'b00));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int N_EXT       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int MACH_CLKS   = 4,
    parameter int MIN_MACH    = 2,
    parameter int SETTLE_W    = 8
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                rst_pin_i,
    input  logic                pcon_we_i,
    input  logic [1:0]          pcon_wdata_i,
    input  logic                irq_pend_i,
    input  logic [N_EXT-1:0]    ext_int_n_i,
    input  logic [SETTLE_W-1:0] settle_len_i,
    output logic [1:0]          pcon_o,
    output logic [1:0]          mode_o,
    output logic                cpu_clk_en_o,
    output logic                per_clk_en_o,
    output logic                osc_en_o,
    output logic                sys_rst_o,
    output logic [N_EXT-1:0]    ext_wake_o
);
    logic      rst_q;
    logic      settle_load;
    logic      settle_active;
    logic      settle_done;
    pm_state_t state;

    pwr_rst_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .MACH_CLKS  (MACH_CLKS),
        .MIN_MACH   (MIN_MACH)
    ) u_filt (
        .clk  (clk),
        .por_n(por_n),
        .pin_i(rst_pin_i),
        .rst_o(rst_q)
    );

    pwr_settle_timer #(.CNT_W(SETTLE_W)) u_settle (
        .clk       (clk),
        .por_n     (por_n),
        .load_i    (settle_load),
        .load_val_i(settle_len_i),
        .active_i  (settle_active),
        .done_o    (settle_done)
    );

    pwr_mode_fsm #(.N_EXT(N_EXT)) u_fsm (
        .clk            (clk),
        .por_n          (por_n),
        .sys_rst_i      (rst_q),
        .pcon_we_i      (pcon_we_i),
        .pcon_wdata_i   (pcon_wdata_i),
        .irq_pend_i     (irq_pend_i),
        .ext_int_n_i    (ext_int_n_i),
        .settle_done_i  (settle_done),
        .settle_load_o  (settle_load),
        .settle_active_o(settle_active),
        .state_o        (state),
        .pcon_o         (pcon_o),
        .cpu_clk_en_o   (cpu_clk_en_o),
        .per_clk_en_o   (per_clk_en_o),
        .osc_en_o       (osc_en_o),
        .ext_wake_o     (ext_wake_o)
    );

    assign mode_o    = state;
    assign sys_rst_o = rst_q;

    // R4
    pdn_all_off_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode_o == 2'b10) |-> (!osc_en_o && !cpu_clk_en_o && !per_clk_en_o));
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;
    localparam int MIN_HI = 8;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_pin = 1'b0;
    logic       we = 1'b0;
    logic [1:0] wdata = 2'b00;
    logic       irq = 1'b0;
    logic [3:0] ext_n = 4'hF;
    logic [7:0] settle_len = 8'd5;
    logic [1:0] pcon, mode;
    logic       cpu_en, per_en, osc_en, srst;
    logic [3:0] wake;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        string      tag;
        logic [1:0] mode;
        logic [1:0] pcon;
        logic [2:0] en;
        logic [3:0] wake;
        logic       rst;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl u_dut (
        .clk(clk), .por_n(por_n), .rst_pin_i(rst_pin), .pcon_we_i(we),
        .pcon_wdata_i(wdata), .irq_pend_i(irq), .ext_int_n_i(ext_n),
        .settle_len_i(settle_len), .pcon_o(pcon), .mode_o(mode),
        .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .osc_en_o(osc_en),
        .sys_rst_o(srst), .ext_wake_o(wake)
    );

    // enables {cpu,per,osc} per mode, taken from the requirements
    function automatic logic [2:0] en_of(logic [1:0] m);
        case (m)
            2'b00:   return 3'b111;
            2'b01:   return 3'b011;
            2'b10:   return 3'b000;
            default: return 3'b001;
        endcase
    endfunction

    task automatic expect_st(string tag, logic [1:0] m, logic [1:0] p, logic [3:0] w, logic r);
        exp_t e;
        e.tag = tag; e.mode = m; e.pcon = p; e.en = en_of(m); e.wake = w; e.rst = r;
        sb_q.push_back(e);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // monitor: compares outputs half a period after each edge
    always @(negedge clk) begin
        exp_t e;
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            total++;
            if ({mode, pcon, cpu_en, per_en, osc_en, wake, srst} !==
                {e.mode, e.pcon, e.en, e.wake, e.rst}) begin
                bad++;
                $display("FAIL %s: act mode=%b pcon=%b en=%b%b%b wake=%b rst=%b exp mode=%b pcon=%b en=%b wake=%b rst=%b",
                         e.tag, mode, pcon, cpu_en, per_en, osc_en, wake, srst,
                         e.mode, e.pcon, e.en, e.wake, e.rst);
            end
        end
    end

    task automatic write_pcon(logic [1:0] d);
        we = 1'b1; wdata = d;
        step();
        we = 1'b0; wdata = 2'b00;
    endtask

    task automatic pin_pulse(int len, string tag, logic [1:0] m, logic [1:0] p, bit accept);
        rst_pin = 1'b1;
        for (int k = 1; k <= MIN_HI + SYNC + 1; k++) begin
            step();
            if (k == len) rst_pin = 1'b0;
            if (accept && k == len + SYNC)          expect_st(tag, m, p, 4'h0, 1'b1);
            else if (accept && k == len + SYNC + 1) expect_st(tag, 2'b00, 2'b00, 4'h0, 1'b0);
            else                                    expect_st(tag, m, p, 4'h0, 1'b0);
        end
    endtask

    initial begin
        repeat (3) step();
        expect_st("R1 in reset", 2'b00, 2'b00, 4'h0, 1'b0);
        por_n = 1'b1;
        step();
        expect_st("R1 after reset", 2'b00, 2'b00, 4'h0, 1'b0);

        write_pcon(2'b01);
        expect_st("R2 idle entry", 2'b01, 2'b01, 4'h0, 1'b0);
        write_pcon(2'b10);
        expect_st("R12 write in idle", 2'b01, 2'b01, 4'h0, 1'b0);
        irq = 1'b1; step(); irq = 1'b0;
        expect_st("R3 idle wake", 2'b00, 2'b00, 4'h0, 1'b0);

        write_pcon(2'b10);
        expect_st("R4 pdn entry", 2'b10, 2'b10, 4'h0, 1'b0);
        irq = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            expect_st("R6 irq in pdn", 2'b10, 2'b10, 4'h0, 1'b0);
        end
        irq = 1'b0;
        write_pcon(2'b01);
        expect_st("R12 write in pdn", 2'b10, 2'b10, 4'h0, 1'b0);

        ext_n = 4'b1011; step(); ext_n = 4'hF;
        expect_st("R7 settle entry", 2'b11, 2'b10, 4'h0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            step();
            expect_st("R7 settling", 2'b11, 2'b10, 4'h0, 1'b0);
        end
        step();
        expect_st("R8 wake vector", 2'b00, 2'b00, 4'b0100, 1'b0);
        step();
        expect_st("R8 wake one cycle", 2'b00, 2'b00, 4'h0, 1'b0);

        settle_len = 8'd0;
        write_pcon(2'b11);
        expect_st("R5 both bits", 2'b10, 2'b10, 4'h0, 1'b0);
        ext_n = 4'b1110; step(); ext_n = 4'hF;
        expect_st("R7 zero settle", 2'b11, 2'b10, 4'h0, 1'b0);
        step();
        expect_st("R8 wake line0", 2'b00, 2'b00, 4'b0001, 1'b0);

        write_pcon(2'b01);
        expect_st("R2 idle again", 2'b01, 2'b01, 4'h0, 1'b0);
        pin_pulse(MIN_HI - 1, "R10 short pulse", 2'b01, 2'b01, 1'b0);
        pin_pulse(MIN_HI, "R9 min pulse", 2'b01, 2'b01, 1'b1);

        write_pcon(2'b10);
        expect_st("R4 pdn again", 2'b10, 2'b10, 4'h0, 1'b0);
        pin_pulse(MIN_HI, "R11 reset in pdn", 2'b10, 2'b10, 1'b1);

        @(negedge clk);
        #1;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: act running exp finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule